// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a synchronous on-chip requester read and write an external asynchronous byte-wide static RAM of 128K locations. The requester offers one access at a time over a valid/ready handshake (address, write data and a direction flag). The controller then steps the memory's active-low chip, output and write enables through a fixed sequence and returns read bytes on a registered, single-cycle response strobe.

Every access runs the same four phases: idle, a one-cycle setup, an access phase lasting `WAIT_CYCLES` cycles, and a one-cycle hold. The address and write data are held for the whole time the chip is enabled. The controller drives the shared data bus only during writes, while output enable is high. Between accesses the chip is deselected, so the memory can drop into its low-power state. The data bus is split into separate out, in and drive-enable signals, and a pad ring can join them later.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: `req_ready` is 1 only while idle with the chip deselected. After a request is accepted, `req_ready` stays 0 for exactly `WAIT_CYCLES`+2 cycles.
- R3: A write has three parts. First, one cycle with `mem_ce_n`=0, `mem_we_n`=1 and the data driven. Then `mem_we_n`=0 for exactly `WAIT_CYCLES` consecutive cycles. Last, one cycle with `mem_we_n`=1 while the chip stays enabled and the data is still driven.
- R4: `mem_oe_n` and `mem_we_n` are never 0 together, and `mem_oe_n` stays 1 through a whole write.
- R5: `mem_dq_oe` is never 1 while `mem_oe_n` is 0, so the controller and the memory never drive the data bus together.
- R6: A read holds `mem_oe_n`=0 for exactly `WAIT_CYCLES` cycles, after a setup cycle with `mem_oe_n`=1. The bus value seen in the last of those cycles is returned on `rsp_rdata`. `rsp_valid` is a one-cycle pulse in the cycle after `mem_oe_n` rises, `WAIT_CYCLES`+1 cycles after the accept edge.
- R7: `mem_addr`, and `mem_dq_out` for writes, do not change while `mem_ce_n` stays 0.
- R8: Each chip-enable window lasts exactly `WAIT_CYCLES`+2 cycles, and `mem_ce_n` is 1 for at least one cycle between two accesses.
- R9: A write never raises `rsp_valid`.
- R10: A read returns the byte most recently written to that address, including at addresses 0 and 0x1FFFF. Request fields that change after the accept edge have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 8 | Read byte |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 17 | Memory address bus |
| mem_dq_out | output | 8 | Data toward memory |
| mem_dq_in | input | 8 | Data from memory |
| mem_dq_oe | output | 1 | Controller data-bus driver enable |

## Verification
Suppose the phase register or the wait counter is wrong. Then a strobe window has the wrong length: the write pulse, the output-enable window or the chip-enable window. The bench sees this at the pins as soon as that strobe returns high, within the same access. A stale direction flag or a mistimed driver enable makes both sides drive the bus, or makes a write pulse happen with the bus undriven. The bench flags that in the very cycle it happens. A wrong capture point or a wrong address register changes a read-back byte, and the bench sees that at the `rsp_valid` pulse of the first read of the affected address.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACCESS = 2'd2,
      PH_HOLD   = 2'd3
   } phase_t;
endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
   import sram_ctrl_pkg::*;
#(
   parameter int WAIT_CYCLES = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   output phase_t phase,
   output logic   access_last
);
   generate
      if (WAIT_CYCLES < 1) begin : g_bad_wait
         $error("sram_ctrl_seq: WAIT_CYCLES must be at least 1");
      end
   endgenerate

   phase_t phase_nx;

   // Wait counter variant: none needed for single-cycle access phase
   generate
      if (WAIT_CYCLES == 1) begin : g_single
         assign access_last = (phase == PH_ACCESS);
      end else begin : g_count
         localparam int CNT_W = $clog2(WAIT_CYCLES);
         localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES - 1);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (phase == PH_ACCESS && cnt != CNT_LAST) begin
               cnt <= cnt + 1'b1;
            end else begin
               cnt <= '0;
            end
         end
         assign access_last = (phase == PH_ACCESS) && (cnt == CNT_LAST);
      end
   endgenerate

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_IDLE:   if (start) phase_nx = PH_SETUP;
         PH_SETUP:  phase_nx = PH_ACCESS;
         PH_ACCESS: if (access_last) phase_nx = PH_HOLD;
         PH_HOLD:   phase_nx = PH_IDLE;
         default:   phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= phase_nx;
   end

   // R8: hold phase always returns to idle (deselect cycle between accesses)
   assert_hold_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HOLD) |=> (phase == PH_IDLE));
   // R3/R6: setup always lasts one cycle
   assert_setup_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SETUP) |=> (phase == PH_ACCESS));
endmodule

// File: rtl/sram_ctrl_path.sv
module sram_ctrl_path #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_write,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [DATA_W-1:0] load_wdata,
   input  logic              capture,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              op_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_ctrl_path: widths must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_write   <= 1'b0;
         mem_addr   <= '0;
         mem_dq_out <= '0;
      end else if (load) begin
         op_write   <= load_write;
         mem_addr   <= load_addr;
         mem_dq_out <= load_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= capture;
         if (capture) rsp_rdata <= mem_dq_in;
      end
   end

   // R6: response strobe is a single-cycle pulse
   assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R9: no capture for a write operation
   assert_no_write_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !load) |-> !op_write);
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W      = 17,
   parameter int DATA_W      = 8,
   parameter int WAIT_CYCLES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);
   phase_t phase;
   logic   access_last;
   logic   op_write;
   logic   start;
   logic   capture;

   assign req_ready = (phase == PH_IDLE);
   assign start     = req_valid && req_ready;
   assign capture   = access_last && !op_write;

   sram_ctrl_seq #(.WAIT_CYCLES(WAIT_CYCLES)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .phase       (phase),
      .access_last (access_last)
   );

   sram_ctrl_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (start),
      .load_write (req_write),
      .load_addr  (req_addr),
      .load_wdata (req_wdata),
      .capture    (capture),
      .mem_dq_in  (mem_dq_in),
      .op_write   (op_write),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata)
   );

   // Strobe decode from registered phase and direction
   always_comb begin
      mem_ce_n  = 1'b1;
      mem_oe_n  = 1'b1;
      mem_we_n  = 1'b1;
      mem_dq_oe = 1'b0;
      unique case (phase)
         PH_SETUP: begin
            mem_ce_n  = 1'b0;
            mem_dq_oe = op_write;
         end
         PH_ACCESS: begin
            mem_ce_n  = 1'b0;
            mem_we_n  = !op_write;
            mem_oe_n  = op_write;
            mem_dq_oe = op_write;
         end
         PH_HOLD: begin
            mem_ce_n  = 1'b0;
            mem_dq_oe = op_write;
         end
         default: ;
      endcase
   end

   // R4: write and output enables never low together
   assert_oe_we_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));
   // R5: controller driver off whenever memory outputs are enabled
   assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);
   // R2: ready only while the chip is deselected
   assert_ready_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));
   // R7: address and write data stable while chip enabled
   assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !$past(mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
   // R3: write pulse preceded by a cycle of driven data with write enable high
   assert_write_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> ($past(mem_dq_oe) && !$past(mem_ce_n)));
endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;
   localparam int AW = 17;
   localparam int DW = 8;
   localparam int WC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_out;
   logic [DW-1:0] mem_dq_in = 8'hEE;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYCLES(WC)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
      .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // ---------------- memory model (sparse byte array) ----------------
   logic [DW-1:0] model_mem [int];
   bit [DW-1:0]   sb [int];

   function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
      if (model_mem.exists(int'(a))) return model_mem[int'(a)];
      return 8'h00;
   endfunction

   function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] a);
      if (sb.exists(int'(a))) return sb[int'(a)];
      return 8'h00;
   endfunction

   int viol_r4 = 0, viol_r5 = 0, viol_r2 = 0, viol_r7 = 0, viol_r9 = 0, viol_wr = 0;
   int we_run = 0, oe_run = 0, ce_run = 0;
   bit prev_ce_low = 0;
   logic [AW-1:0] prev_addr = '0;
   logic [DW-1:0] prev_dout = '0;
   bit acc_write = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         // memory drives the bus only when enabled for a read
         if (!mem_ce_n && !mem_oe_n && mem_we_n) mem_dq_in <= model_rd(mem_addr);
         else                                     mem_dq_in <= 8'hEE;
         if (!mem_ce_n && !mem_we_n) begin
            if (!mem_dq_oe || !mem_oe_n) begin
               viol_wr++;
               $display("FAIL R3: write pulse with bus undriven (dq_oe %0b oe_n %0b) expected 1 1", mem_dq_oe, mem_oe_n);
            end
            model_mem[int'(mem_addr)] = mem_dq_out;
         end
         if (!mem_oe_n && !mem_we_n) begin
            viol_r4++; $display("FAIL R4: oe_n and we_n both 0, expected never");
         end
         if (mem_dq_oe && !mem_ce_n && !mem_oe_n && mem_we_n) begin
            viol_r5++; $display("FAIL R5: bus contention dq_oe 1 with oe_n 0, expected dq_oe 0");
         end
         if (req_ready && !mem_ce_n) begin
            viol_r2++; $display("FAIL R2: req_ready 1 with ce_n 0, expected ce_n 1");
         end
         if (rsp_valid && acc_write) begin
            viol_r9++; $display("FAIL R9: rsp_valid 1 during write, expected 0");
         end
         if (!mem_ce_n && prev_ce_low && (mem_addr != prev_addr || (acc_write && mem_dq_out != prev_dout))) begin
            viol_r7++; $display("FAIL R7: addr/data %0h/%0h changed from %0h/%0h", mem_addr, mem_dq_out, prev_addr, prev_dout);
         end
         if (!mem_ce_n && !prev_ce_low) begin
            check("R3 setup we_n high on first enabled cycle", {31'd0, mem_we_n}, 32'd1);
            check("R6 setup oe_n high on first enabled cycle", {31'd0, mem_oe_n}, 32'd1);
         end
         // strobe window lengths
         if (!mem_we_n) we_run++;
         else if (we_run != 0) begin
            check("R3 we_n low length", we_run, WC);
            check("R3 hold cycle ce_n low after write pulse", {31'd0, mem_ce_n}, 32'd0);
            we_run = 0;
         end
         if (!mem_oe_n) oe_run++;
         else if (oe_run != 0) begin
            check("R6 oe_n low length", oe_run, WC);
            oe_run = 0;
         end
         if (!mem_ce_n) ce_run++;
         else if (ce_run != 0) begin
            check("R8 ce_n low window length", ce_run, WC + 2);
            ce_run = 0;
         end
         prev_ce_low = !mem_ce_n;
         prev_addr   = mem_addr;
         prev_dout   = mem_dq_out;
      end
   end

   // ---------------- requester tasks ----------------
   task automatic do_access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                            output logic [DW-1:0] q, output int lat);
      int guard = 0;
      while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      acc_write = wr;
      @(negedge clk);
      // scramble request fields after acceptance: must not matter (R10)
      req_valid = 1'b0; req_addr = AW'($urandom); req_wdata = DW'($urandom); req_write = ~wr;
      lat = 0; q = '0;
      if (!wr) begin
         while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
         q = rsp_rdata;
      end else begin
         while (!req_ready && lat < 50) begin @(negedge clk); lat++; end
      end
   endtask

   task automatic wr_byte(input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic [DW-1:0] q; int lat;
      do_access(1'b1, a, d, q, lat);
      sb[int'(a)] = d;
      check("R2 ready low window after write accept", lat, WC + 2);
   endtask

   task automatic rd_byte(input logic [AW-1:0] a);
      logic [DW-1:0] q; int lat;
      do_access(1'b0, a, '0, q, lat);
      check("R6 read response latency", lat, WC + 1);
      check("R10 read-back data", q, expect_rd(a));
      @(negedge clk);
      check("R6 rsp_valid single-cycle pulse", {31'd0, rsp_valid}, 32'd0);
      check("R2 ready after read", {31'd0, req_ready}, 32'd1);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual timeout expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // ---------------- main stimulus ----------------
   initial begin
      logic [AW-1:0] pool [16];
      int seed_dummy;
      seed_dummy = $urandom(32'h5EED_1234);
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 ce_n in reset", {31'd0, mem_ce_n}, 32'd1);
      check("R1 oe_n in reset", {31'd0, mem_oe_n}, 32'd1);
      check("R1 we_n in reset", {31'd0, mem_we_n}, 32'd1);
      check("R1 dq_oe in reset", {31'd0, mem_dq_oe}, 32'd0);
      check("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle strobes after reset", {28'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 32'hE);
      check("R2 ready when idle", {31'd0, req_ready}, 32'd1);

      // directed corners: address extremes, data extremes
      wr_byte(17'h00000, 8'h00);
      wr_byte(17'h1FFFF, 8'hFF);
      wr_byte(17'h00001, 8'hA5);
      rd_byte(17'h1FFFF);
      rd_byte(17'h00000);
      rd_byte(17'h00001);
      // overwrite, then read back latest value (R10)
      wr_byte(17'h00001, 8'h5A);
      rd_byte(17'h00001);
      // back-to-back read then write (turnaround)
      rd_byte(17'h1FFFF);
      wr_byte(17'h1FFFF, 8'h3C);
      rd_byte(17'h1FFFF);

      // constrained random mix over a small address pool
      foreach (pool[i]) pool[i] = AW'($urandom);
      for (int k = 0; k < 400; k++) begin
         automatic logic [AW-1:0] a = pool[$urandom_range(0, 15)];
         if (!sb.exists(int'(a)) || ($urandom_range(0, 1) == 0))
            wr_byte(a, DW'($urandom));
         else
            rd_byte(a);
      end
      foreach (pool[i]) if (sb.exists(int'(pool[i]))) rd_byte(pool[i]);

      repeat (4) @(negedge clk);
      check("R1 idle strobes at end", {28'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 32'hE);
      check("R4 oe/we overlap count", viol_r4, 0);
      check("R5 bus contention count", viol_r5, 0);
      check("R2 ready-while-enabled count", viol_r2, 0);
      check("R7 address/data change count", viol_r7, 0);
      check("R9 write response count", viol_r9, 0);
      check("R3 undriven write pulse count", viol_wr, 0);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule